// File: doc/BRIEF.md
# Serial EEPROM Byte Access Engine

This block performs single-byte reads and writes on an external serial EEPROM that sits on an SPI bus in mode 0 (clock idles low). A host presents one request at a time: a direction flag, a 16-bit address and, for writes, one data byte. The engine then drives chip select, the serial clock and the serial output line, and samples the serial input line until the access is finished.

A read is a single chip-select frame. It carries the read opcode, both address bytes and one dummy byte, and the byte the device returns during the dummy byte becomes the result. A write runs a fixed sequence of three steps. First it polls the device status register, one complete frame per poll, until the busy bit is clear. Next it sends the write-enable opcode alone in its own frame. Last it sends the write frame with the opcode, the address and the data byte. The engine inserts idle gaps of a set number of system clocks around every chip-select edge, and it derives the serial clock from the system clock through a divider.

Top module: `spi_eeprom_seq`

## Requirements
- R1: While reset is asserted and right after it, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: A write request starts with status-poll frames. Each poll is its own frame of exactly two bytes, 0x05 then 0x00. Polling repeats while bit 0 of the returned second byte is 1 and stops on the first poll that returns 0.
- R3: After the final poll, a frame holding only the byte 0x06 is sent, and chip select goes high before the next frame begins.
- R4: The write then ends with one frame of four bytes: 0x02, address bits 15:8, address bits 7:0, and the data byte.
- R5: A read request is one frame of four bytes: 0x03, address bits 15:8, address bits 7:0, and 0x00. `rdata` holds the byte returned during the fourth byte once `done` pulses.
- R6: Bytes are sent MSB first in SPI mode 0. `sclk` is 0 whenever `cs_n` is 1 or changes. `mosi` never changes while `sclk` stays high.
- R7: Inside a frame, each high and low phase of `sclk` lasts exactly CLK_DIV system clocks.
- R8: At least GAP system clocks separate each falling `cs_n` from the first rising `sclk`, the last falling `sclk` from the rising `cs_n`, and each rising `cs_n` from the next falling `cs_n`.
- R9: `busy` is 1 from the cycle after a request is accepted until the access ends. A request presented while `busy` is 1 has no effect.
- R10: `done` is a one-cycle pulse that appears in the same cycle as `cs_n` rises at the end of the last frame of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address in the EEPROM |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse when the access ends |
| rdata | output | 8 | Result of the latest read |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The hardest case to reach from the ports is a write in which the status register reports busy on several polls in a row. Only the device can set that bit, and it has to clear at the right moment. The behavioural EEPROM model in the bench therefore takes a preset number of busy replies for each write, and the stimulus varies that number from zero to three, some of it chosen at random. Requests presented while an access is running are also injected, and the frame log is checked to confirm they left no trace.

// File: rtl/spi_eeprom_seq.sv
`timescale 1ns/1ps
module spi_eeprom_seq #(
  parameter int CLK_DIV = 2,
  parameter int GAP     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdata,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int GW = $clog2(GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL, S_SPACE} state_t;
  typedef enum logic [1:0] {F_POLL, F_WREN, F_WRITE, F_READ} frame_t;

  state_t      state;
  frame_t      frame;
  logic [15:0] addr;
  logic [7:0]  wdata, tx, rx, rdata_q;
  logic [2:0]  bcnt;
  logic [1:0]  idx, last_idx;
  logic [DW-1:0] dcnt;
  logic [GW-1:0] gcnt;
  logic        sclk_q, wip, done_q, last_q;

  function automatic logic [7:0] byte_at(frame_t f, logic [1:0] i, logic [15:0] a, logic [7:0] d);
    case (f)
      F_POLL:  return (i == 2'd0) ? 8'h05 : 8'h00;
      F_WREN:  return 8'h06;
      F_WRITE: case (i)
                 2'd0: return 8'h02;
                 2'd1: return a[15:8];
                 2'd2: return a[7:0];
                 default: return d;
               endcase
      default: case (i)
                 2'd0: return 8'h03;
                 2'd1: return a[15:8];
                 2'd2: return a[7:0];
                 default: return 8'h00;
               endcase
    endcase
  endfunction

  assign last_idx = (frame == F_POLL) ? 2'd1 : (frame == F_WREN) ? 2'd0 : 2'd3;
  wire gap_end = (gcnt == GW'(GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; frame <= F_READ; addr <= '0; wdata <= '0;
      tx <= '0; rx <= '0; bcnt <= '0; idx <= '0; dcnt <= '0; gcnt <= '0;
      sclk_q <= 1'b0; wip <= 1'b0; rdata_q <= '0; done_q <= 1'b0; last_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr  <= req_addr;
          wdata <= req_wdata;
          frame <= req_write ? F_POLL : F_READ;
          tx    <= req_write ? 8'h05 : 8'h03;
          gcnt  <= '0;
          state <= S_LEAD;
        end
        S_LEAD: if (gap_end) begin
          gcnt <= '0; dcnt <= '0; bcnt <= '0; idx <= '0;
          state <= S_SHIFT;
        end else gcnt <= gcnt + 1'b1;
        S_SHIFT: if (dcnt == DW'(CLK_DIV - 1)) begin
          dcnt   <= '0;
          sclk_q <= !sclk_q;
          if (!sclk_q) rx <= {rx[6:0], miso};
          else if (bcnt != 3'd7) begin
            bcnt <= bcnt + 1'b1;
            tx   <= {tx[6:0], 1'b0};
          end else begin
            bcnt <= '0;
            if (frame == F_POLL && idx == 2'd1) wip <= rx[0];
            if (frame == F_READ && idx == 2'd3) rdata_q <= rx;
            if (idx == last_idx) begin
              state <= S_TRAIL;
              gcnt  <= '0;
            end else begin
              idx <= idx + 2'd1;
              tx  <= byte_at(frame, idx + 2'd1, addr, wdata);
            end
          end
        end else dcnt <= dcnt + 1'b1;
        S_TRAIL: if (gap_end) begin
          gcnt  <= '0;
          state <= S_SPACE;
          case (frame)
            F_POLL:  frame <= wip ? F_POLL : F_WREN;
            F_WREN:  frame <= F_WRITE;
            default: begin last_q <= 1'b1; done_q <= 1'b1; end
          endcase
        end else gcnt <= gcnt + 1'b1;
        default: if (gap_end) begin
          gcnt <= '0;
          if (last_q) begin
            last_q <= 1'b0;
            state  <= S_IDLE;
          end else begin
            state <= S_LEAD;
            tx    <= byte_at(frame, 2'd0, addr, wdata);
          end
        end else gcnt <= gcnt + 1'b1;
      endcase
    end
  end

  assign cs_n  = !(state == S_LEAD || state == S_SHIFT || state == S_TRAIL);
  assign busy  = (state != S_IDLE);
  assign done  = done_q;
  assign rdata = rdata_q;
  assign sclk  = sclk_q;
  assign mosi  = tx[7];

  AST_CS_EDGE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> !sclk);                                      // R6
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);                                                // R6
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));                       // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                // R10
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n)));                               // R10
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);                                                 // R9
endmodule

// File: tb/test_spi_eeprom_seq.sv
`timescale 1ns/1ps
module test_spi_eeprom_seq;
  localparam int CLK_DIV = 2;
  localparam int GAP     = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic busy, done, cs_n, sclk, mosi, miso;
  logic [7:0] rdata;

  spi_eeprom_seq #(.CLK_DIV(CLK_DIV), .GAP(GAP)) i_spi_eeprom_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #5 clk = !clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural EEPROM
  logic [7:0] mem [logic [15:0]];
  logic [7:0] ref_mem [logic [15:0]];
  logic [7:0] m_in = '0, m_out = '0;
  logic [7:0] fr [0:3];
  int m_bits = 0, m_idx = 0, m_wip = 0;
  bit m_pend = 0, m_wel = 0;
  logic [7:0] log_b [0:15][0:3];
  int log_len [0:15];
  int nfr = 0;

  assign miso = m_out[7];

  function automatic logic [7:0] reply();
    logic [15:0] a;
    a = {fr[1], fr[2]};
    if (fr[0] == 8'h05 && m_idx == 1) return {7'd0, m_wip > 0};
    if (fr[0] == 8'h03 && m_idx == 3) return mem.exists(a) ? mem[a] : 8'hFF;
    return 8'h00;
  endfunction

  always @(negedge cs_n) begin
    m_bits = 0; m_idx = 0; m_pend = 0; m_out = 8'h00;
    for (int k = 0; k < 4; k++) fr[k] = 8'h00;
  end

  always @(posedge sclk) if (!cs_n) begin
    m_in = {m_in[6:0], mosi};
    m_bits++;
    if (m_bits == 8) begin
      if (m_idx < 4) fr[m_idx] = m_in;
      m_idx++;
      m_bits = 0;
      m_pend = 1;
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    if (m_pend) begin m_pend = 0; m_out = reply(); end
    else m_out = {m_out[6:0], 1'b0};
  end

  always @(posedge cs_n) if (m_idx > 0) begin
    if (nfr < 16) begin
      for (int k = 0; k < 4; k++) log_b[nfr][k] = fr[k];
      log_len[nfr] = m_idx;
    end
    nfr++;
    if (fr[0] == 8'h06 && m_idx == 1) m_wel = 1;
    if (fr[0] == 8'h05 && m_idx == 2 && m_wip > 0) m_wip--;
    if (fr[0] == 8'h02 && m_idx == 4 && m_wel && m_wip == 0) mem[{fr[1], fr[2]}] = fr[3];
    if (fr[0] == 8'h02) m_wel = 0;
    m_idx = 0;
  end

  // timing monitor
  localparam int EV_NONE = 0, EV_CSF = 1, EV_CSR = 2, EV_SCK = 3;
  int since = 0, last_ev = EV_NONE, err_period = 0, err_gap = 0, err_mode = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

  always @(negedge clk) if (rst_n) begin
    since++;
    if (cs_n !== p_cs) begin
      if (sclk) err_mode++;
      if (!cs_n) begin
        if (last_ev == EV_CSR && since < GAP) err_gap++;
        last_ev = EV_CSF;
      end else begin
        if (last_ev == EV_SCK && since < GAP) err_gap++;
        last_ev = EV_CSR;
      end
      since = 0;
    end else if (sclk !== p_sclk) begin
      if (last_ev == EV_SCK && since != CLK_DIV) err_period++;
      if (last_ev == EV_CSF && since < GAP) err_gap++;
      last_ev = EV_SCK;
      since = 0;
    end
    if (sclk && p_sclk && mosi !== p_mosi) err_mode++;
    p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
  end

  function automatic logic [39:0] fpack(int k);
    return {log_len[k][7:0], log_b[k][0], log_b[k][1], log_b[k][2], log_b[k][3]};
  endfunction

  task automatic finish_access();
    while (done !== 1'b1) @(negedge clk);
    check(cs_n === 1'b1, "R10 cs_n at done", {39'd0, cs_n}, 40'd1);
    @(negedge clk);
    check(done === 1'b0, "R10 done width", {39'd0, done}, 40'd0);
    while (busy) @(negedge clk);
    check(err_mode == 0, "R6 mode 0 timing", err_mode, 0);
    check(err_period == 0, "R7 sclk phase", err_period, 0);
    check(err_gap == 0, "R8 cs gaps", err_gap, 0);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input int polls, input bit inject);
    m_wip = polls; nfr = 0;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check(busy === 1'b1, "R9 busy after accept", {39'd0, busy}, 40'd1);
    if (inject) begin
      repeat (8) @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = ~a;
      repeat (3) @(negedge clk);
      req_valid = 0;
    end
    finish_access();
    check(nfr == polls + 3, "R9 frame count on write", nfr, polls + 3);
    for (int i = 0; i <= polls && i < 14; i++)
      check(fpack(i) == {8'd2, 8'h05, 8'h00, 16'h0}, "R2 poll frame", fpack(i), {8'd2, 8'h05, 8'h00, 16'h0});
    if (polls + 2 < 16) begin
      check(fpack(polls + 1) == {8'd1, 8'h06, 24'h0}, "R3 enable frame", fpack(polls + 1), {8'd1, 8'h06, 24'h0});
      check(fpack(polls + 2) == {8'd4, 8'h02, a, d}, "R4 write frame", fpack(polls + 2), {8'd4, 8'h02, a, d});
    end
    ref_mem[a] = d;
  endtask

  task automatic do_read(input logic [15:0] a, input bit inject);
    logic [7:0] e;
    e = ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
    nfr = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(busy === 1'b1, "R9 busy after accept", {39'd0, busy}, 40'd1);
    if (inject) begin
      repeat (5) @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = ~a; req_wdata = 8'h5A;
      repeat (3) @(negedge clk);
      req_valid = 0;
    end
    finish_access();
    check(nfr == 1, "R9 frame count on read", nfr, 1);
    check(fpack(0) == {8'd4, 8'h03, a, 8'h00}, "R5 read frame", fpack(0), {8'd4, 8'h03, a, 8'h00});
    check(rdata == e, "R5 read data", {32'd0, rdata}, {32'd0, e});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected access end");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  logic [15:0] pool [0:3];

  initial begin
    pool[0] = 16'h0000; pool[1] = 16'h00FF; pool[2] = 16'h8001; pool[3] = 16'hFFFF;
    void'($urandom(32'hC0FFEE));
    repeat (4) @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset state",
          {36'd0, cs_n, sclk, busy, done}, {36'd0, 4'b1000});
    rst_n = 1;
    @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0, "R1 after reset",
          {37'd0, cs_n, sclk, busy}, {37'd0, 3'b100});
    do_write(16'h0000, 8'hA5, 0, 0);
    do_read(16'h0000, 0);
    do_write(16'hFFFF, 8'h3C, 2, 1);
    do_read(16'hFFFF, 1);
    do_read(16'h1234, 0);
    do_write(16'h1234, 8'h81, 3, 0);
    do_read(16'h1234, 0);
    for (int n = 0; n < 24; n++) begin
      logic [15:0] a;
      a = pool[$urandom_range(3)];
      if ($urandom_range(1)) do_write(a, 8'($urandom), $urandom_range(3), $urandom_range(1));
      else do_read(a, $urandom_range(1));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule